// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide NOR flash model. It watches the write cycles presented by the host, each carrying an 18-bit address and an 8-bit data byte. It recognises the key-prefixed command sequences and turns each completed sequence into a request that lasts one cycle. The requests are program byte, chip erase, block erase, boot-lock enable, identification-mode entry and identification-mode exit. It also keeps a flag that says whether reads should come from the array or from the identification space.

Every multi-cycle command opens with a two-write key: AAh at 555h, then 55h at 2AAh. The third write selects a branch. A program is armed by A0h, and the next write then carries the target address and byte. Identification entry uses 90h. The three-write exit uses F0h. An extended prefix uses 80h and needs a second key pair. Its sixth write selects chip erase, block erase or lock enable. Identification mode can also be left with a single F0h write at any address.

Any write that breaks the expected sequence returns the decoder to idle, and no request is issued for it. While the operation controller raises `busy`, every write is ignored, as it is for the whole of a chip erase. The array itself, the operation timers and the read path are handled elsewhere.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After a synchronous active-low reset, `req_valid` and `id_mode` are 0 and the decoder waits for the first key write.
- R2: The writes AAh@555h, 55h@2AAh and A0h@555h, followed by any fourth write, produce a program request (`req_op` = 1) that carries the fourth write's full address and data.
- R3: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h and 55h@2AAh form the extended prefix. Its sixth write selects the request: 10h@555h gives chip erase (`req_op` = 2), 30h at any address gives block erase (`req_op` = 3) with that address, and 40h@555h gives lock enable (`req_op` = 4). Any other sixth write gives no request.
- R4: The key pair followed by 90h@555h gives an identification-entry request (`req_op` = 5) and sets `id_mode` to 1.
- R5: Identification exit (`req_op` = 6) clears `id_mode`. It is produced by the key pair followed by F0h@555h, or by a single F0h write at any address while the decoder is idle.
- R6: A lock-enable request also sets `id_mode` to 1, so an exit is needed before array reads resume.
- R7: A write whose address or data does not match the next expected step returns the decoder to idle and produces no request. A full correct sequence that follows is accepted.
- R8: A write made while `busy` is 1 produces no request and leaves the sequence position unchanged.
- R9: Only address bits [11:0] are compared against 555h and 2AAh. The upper address bits do not affect key matching.
- R10: A request is registered. `req_valid` is high in the cycle after the write that completes a sequence, and it is 0 in the cycle after any cycle with no accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | A write cycle is presented this clock |
| wr_addr | input | 18 | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | Operation in progress; writes are ignored |
| req_valid | output | 1 | One-cycle request strobe |
| req_op | output | 3 | Request code (1 program, 2 chip erase, 3 block erase, 4 lock enable, 5 ID entry, 6 ID exit) |
| req_addr | output | 18 | Address carried by the request |
| req_data | output | 8 | Data carried by the request |
| id_mode | output | 1 | 1 while identification mode is active |

## Verification
The third-cycle command byte and the sixth-cycle select byte are each swept over all 256 values. The expected request is computed from the byte, which separates the decoded branches from all the bytes that must be rejected. Each of the six prefix steps is also broken in turn, once by a single data bit and once by a single address bit. Each break is followed by a clean sequence, which shows both that the broken step is rejected and that the decoder recovers to idle. Busy writes are inserted before each step of a program sequence, which shows that such a write neither completes nor resets a sequence. Keys presented with the upper address bits set separate low-bit matching from full-address matching.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [2:0] {
      OP_NONE     = 3'd0,
      OP_PROG     = 3'd1,
      OP_CHIP     = 3'd2,
      OP_BLOCK    = 3'd3,
      OP_LOCK     = 3'd4,
      OP_ID_ENTER = 3'd5,
      OP_ID_EXIT  = 3'd6
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_KEY1,
      ST_KEY2,
      ST_PROG_ARM,
      ST_EXT_KEY1,
      ST_EXT_KEY2,
      ST_EXT_SEL
   } st_e;

   localparam logic [7:0] CODE_KEY_A = 8'hAA;
   localparam logic [7:0] CODE_KEY_B = 8'h55;
   localparam logic [7:0] CODE_PROG  = 8'hA0;
   localparam logic [7:0] CODE_EXT   = 8'h80;
   localparam logic [7:0] CODE_ID    = 8'h90;
   localparam logic [7:0] CODE_EXIT  = 8'hF0;
   localparam logic [7:0] CODE_CHIP  = 8'h10;
   localparam logic [7:0] CODE_BLOCK = 8'h30;
   localparam logic [7:0] CODE_LOCK  = 8'h40;

   localparam logic [11:0] KEY_ADDR_A = 12'h555;
   localparam logic [11:0] KEY_ADDR_B = 12'h2AA;

endpackage

// File: rtl/flash_cmd_addr_match.sv
module flash_cmd_addr_match #(
   parameter int ADDR_W = 18,
   parameter int CMP_W  = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit_a,
   output logic              hit_b
);
   import flash_cmd_pkg::*;

   localparam logic [CMP_W-1:0] KEY_A = CMP_W'(KEY_ADDR_A);
   localparam logic [CMP_W-1:0] KEY_B = CMP_W'(KEY_ADDR_B);

   generate
      if (CMP_W == ADDR_W) begin : g_full
         assign hit_a = (addr == KEY_A);
         assign hit_b = (addr == KEY_B);
      end else begin : g_low
         logic unused_hi;
         assign unused_hi = ^addr[ADDR_W-1:CMP_W];
         assign hit_a = (addr[CMP_W-1:0] == KEY_A);
         assign hit_b = (addr[CMP_W-1:0] == KEY_B);
      end
   endgenerate

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              busy,
   input  logic [DATA_W-1:0] data,
   input  logic              hit_a,
   input  logic              hit_b,
   output logic              fire,
   output flash_cmd_pkg::op_e op
);
   import flash_cmd_pkg::*;

   st_e st_q, st_d;
   logic take;

   assign take = wr_en && !busy;

   always_comb begin
      st_d = st_q;
      fire = 1'b0;
      op   = OP_NONE;
      if (take) begin
         st_d = ST_IDLE;
         case (st_q)
            ST_IDLE: begin
               if (data == CODE_KEY_A && hit_a) begin
                  st_d = ST_KEY1;
               end else if (data == CODE_EXIT) begin
                  fire = 1'b1;
                  op   = OP_ID_EXIT;
               end
            end
            ST_KEY1: begin
               if (data == CODE_KEY_B && hit_b) st_d = ST_KEY2;
            end
            ST_KEY2: begin
               if (hit_a) begin
                  case (data)
                     CODE_PROG: st_d = ST_PROG_ARM;
                     CODE_EXT:  st_d = ST_EXT_KEY1;
                     CODE_ID: begin
                        fire = 1'b1;
                        op   = OP_ID_ENTER;
                     end
                     CODE_EXIT: begin
                        fire = 1'b1;
                        op   = OP_ID_EXIT;
                     end
                     default: ;
                  endcase
               end
            end
            ST_PROG_ARM: begin
               fire = 1'b1;
               op   = OP_PROG;
            end
            ST_EXT_KEY1: begin
               if (data == CODE_KEY_A && hit_a) st_d = ST_EXT_KEY2;
            end
            ST_EXT_KEY2: begin
               if (data == CODE_KEY_B && hit_b) st_d = ST_EXT_SEL;
            end
            ST_EXT_SEL: begin
               if (data == CODE_BLOCK) begin
                  fire = 1'b1;
                  op   = OP_BLOCK;
               end else if (hit_a && data == CODE_CHIP) begin
                  fire = 1'b1;
                  op   = OP_CHIP;
               end else if (hit_a && data == CODE_LOCK) begin
                  fire = 1'b1;
                  op   = OP_LOCK;
               end
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/flash_cmd_req_reg.sv
module flash_cmd_req_reg #(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  flash_cmd_pkg::op_e op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              req_valid,
   output logic [2:0]        req_op,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_data,
   output logic              id_mode
);
   import flash_cmd_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         req_op    <= OP_NONE;
         req_addr  <= '0;
         req_data  <= '0;
         id_mode   <= 1'b0;
      end else begin
         req_valid <= fire;
         if (fire) begin
            req_op   <= op;
            req_addr <= addr;
            req_data <= data;
            if (op == OP_ID_ENTER || op == OP_LOCK) id_mode <= 1'b1;
            else if (op == OP_ID_EXIT)               id_mode <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 8,
   parameter int CMP_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              busy,
   output logic              req_valid,
   output logic [2:0]        req_op,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_data,
   output logic              id_mode
);
   import flash_cmd_pkg::*;

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("DATA_W must be 8 for the command codes");
      end
      if (CMP_W < 12 || CMP_W > ADDR_W) begin : g_bad_cmp
         $error("CMP_W must lie between 12 and ADDR_W");
      end
   endgenerate

   logic hit_a, hit_b, fire;
   op_e  op;

   flash_cmd_addr_match #(.ADDR_W(ADDR_W), .CMP_W(CMP_W)) u_match (
      .addr (wr_addr),
      .hit_a(hit_a),
      .hit_b(hit_b)
   );

   flash_cmd_fsm #(.DATA_W(DATA_W)) u_fsm (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(wr_en),
      .busy (busy),
      .data (wr_data),
      .hit_a(hit_a),
      .hit_b(hit_b),
      .fire (fire),
      .op   (op)
   );

   flash_cmd_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .op       (op),
      .addr     (wr_addr),
      .data     (wr_data),
      .req_valid(req_valid),
      .req_op   (req_op),
      .req_addr (req_addr),
      .req_data (req_data),
      .id_mode  (id_mode)
   );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 8,
   parameter int CMP_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              busy,
   input logic              req_valid,
   input logic [2:0]        req_op,
   input logic [ADDR_W-1:0] req_addr,
   input logic [DATA_W-1:0] req_data,
   input logic              id_mode
);

   // R8
   busy_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> !req_valid);

   // R10
   no_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !req_valid);

   // R2
   prog_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd1) |->
         (req_addr == $past(wr_addr) && req_data == $past(wr_data)));

   // R3
   chip_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 3'd2) |->
         ($past(wr_data) == 8'h10 && $past(wr_addr[CMP_W-1:0]) == CMP_W'(12'h555)));

   // R4
   id_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(id_mode) |-> (req_valid && (req_op == 3'd5 || req_op == 3'd4)));

   // R5
   id_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(id_mode) |-> (req_valid && req_op == 3'd6));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .busy     (busy),
   .req_valid(req_valid),
   .req_op   (req_op),
   .req_addr (req_addr),
   .req_data (req_data),
   .id_mode  (id_mode)
);

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [17:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        busy = 1'b0;
   logic        req_valid;
   logic [2:0]  req_op;
   logic [17:0] req_addr;
   logic [7:0]  req_data;
   logic        id_mode;

   int tests = 0;
   int fails = 0;

   always #4 clk = ~clk;

   flash_cmd_decoder u_flash_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .req_valid(req_valid),
      .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
      .id_mode(id_mode)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [17:0] a, input logic [7:0] d, input logic b);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; busy = b;
      @(negedge clk);
      wr_en = 1'b0; busy = 1'b0;
   endtask

   // op 0 means no request is expected
   task automatic exp_req(input int op, input logic [17:0] a, input logic [7:0] d, input string tag);
      if (op == 0) begin
         chk(req_valid == 1'b0, tag, int'(req_valid), 0);
      end else begin
         chk(req_valid == 1'b1 && int'(req_op) == op, tag, int'(req_op), op);
         if (op == 1 || op == 3) chk(req_addr == a, tag, int'(req_addr), int'(a));
         if (op == 1)            chk(req_data == d, tag, int'(req_data), int'(d));
      end
   endtask

   task automatic key_pair(input logic [17:0] hi);
      wr(hi | 18'h555, 8'hAA, 1'b0);
      wr(hi | 18'h2AA, 8'h55, 1'b0);
   endtask

   function automatic int third_op(input logic [7:0] d);
      if (d == 8'h90) return 5;
      if (d == 8'hF0) return 6;
      return 0;
   endfunction

   function automatic int sixth_op(input logic [7:0] d);
      if (d == 8'h10) return 2;
      if (d == 8'h30) return 3;
      if (d == 8'h40) return 4;
      return 0;
   endfunction

   logic [17:0] seq_a [6];
   logic [7:0]  seq_d [6];

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      seq_a[0] = 18'h555; seq_d[0] = 8'hAA;
      seq_a[1] = 18'h2AA; seq_d[1] = 8'h55;
      seq_a[2] = 18'h555; seq_d[2] = 8'h80;
      seq_a[3] = 18'h555; seq_d[3] = 8'hAA;
      seq_a[4] = 18'h2AA; seq_d[4] = 8'h55;
      seq_a[5] = 18'h555; seq_d[5] = 8'h10;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_valid == 1'b0, "R1 req_valid", int'(req_valid), 0);
      chk(id_mode == 1'b0, "R1 id_mode", int'(id_mode), 0);
      rst_n = 1'b1;

      // R2 program, full address carried
      key_pair(18'h0);
      wr(18'h555, 8'hA0, 1'b0);
      wr(18'h3FFFF, 8'h5A, 1'b0);
      exp_req(1, 18'h3FFFF, 8'h5A, "R2 program");
      @(negedge clk);
      // R10 single-cycle strobe
      exp_req(0, 0, 0, "R10 strobe drops");

      // R3 block erase at arbitrary address, R9 keys with upper bits set
      key_pair(18'h3F000);
      wr(18'h1F555, 8'h80, 1'b0);
      key_pair(18'h2A000);
      wr(18'h2ABCD, 8'h30, 1'b0);
      exp_req(3, 18'h2ABCD, 0, "R3 R9 block erase");

      // R4 entry, R5 three-cycle exit
      key_pair(18'h0);
      wr(18'h555, 8'h90, 1'b0);
      exp_req(5, 0, 0, "R4 id entry");
      chk(id_mode == 1'b1, "R4 id_mode set", int'(id_mode), 1);
      key_pair(18'h0);
      wr(18'h555, 8'hF0, 1'b0);
      exp_req(6, 0, 0, "R5 three-cycle exit");
      chk(id_mode == 1'b0, "R5 id_mode clear", int'(id_mode), 0);

      // R6 lock enable enters id mode; R5 single-write exit
      for (int i = 0; i < 5; i++) wr(seq_a[i], seq_d[i], 1'b0);
      wr(18'h555, 8'h40, 1'b0);
      exp_req(4, 0, 0, "R6 lock enable");
      chk(id_mode == 1'b1, "R6 id_mode after lock", int'(id_mode), 1);
      wr(18'h12345, 8'hF0, 1'b0);
      exp_req(6, 0, 0, "R5 single exit");
      chk(id_mode == 1'b0, "R5 id_mode after single exit", int'(id_mode), 0);

      // R4 R5 R2 sweep of the third-cycle command byte
      for (int d = 0; d < 256; d++) begin
         key_pair(18'h0);
         wr(18'h555, 8'(d), 1'b0);
         exp_req(third_op(8'(d)), 0, 0, "R4 R5 third-cycle sweep");
         wr(18'h0, 8'h00, 1'b0);
         exp_req((d == 8'hA0) ? 1 : 0, 18'h0, 8'h00, "R2 R7 third-cycle follow-up");
         chk(id_mode == (d == 8'h90), "R4 id_mode sweep", int'(id_mode), int'(d == 8'h90));
         wr(18'h0, 8'hF0, 1'b0);
         exp_req(6, 0, 0, "R5 sweep cleanup exit");
      end

      // R3 sweep of the sixth-cycle select byte
      for (int d = 0; d < 256; d++) begin
         for (int i = 0; i < 5; i++) wr(seq_a[i], seq_d[i], 1'b0);
         wr(18'h555, 8'(d), 1'b0);
         exp_req(sixth_op(8'(d)), 18'h555, 0, "R3 sixth-cycle sweep");
         chk(id_mode == (d == 8'h40), "R6 id_mode sixth sweep", int'(id_mode), int'(d == 8'h40));
         wr(18'h0, 8'hF0, 1'b0);
      end

      // R7 break each prefix step by one data bit, then one address bit
      for (int mode = 0; mode < 2; mode++) begin
         for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < k; i++) begin
               wr(seq_a[i], seq_d[i], 1'b0);
               exp_req(0, 0, 0, "R7 prefix step quiet");
            end
            if (mode == 0) wr(seq_a[k], seq_d[k] ^ 8'h01, 1'b0);
            else           wr(seq_a[k] ^ 18'h001, seq_d[k], 1'b0);
            exp_req(0, 0, 0, "R7 broken step");
            for (int i = 0; i < 6; i++) wr(seq_a[i], seq_d[i], 1'b0);
            exp_req(2, 0, 0, "R7 recovery chip erase");
         end
      end

      // R8 busy write before each program step is ignored
      for (int k = 0; k < 4; k++) begin
         for (int i = 0; i < 4; i++) begin
            if (i == k) begin
               wr(18'h0, 8'h00, 1'b1);
               exp_req(0, 0, 0, "R8 busy write");
            end
            if (i == 0)      wr(18'h555, 8'hAA, 1'b0);
            else if (i == 1) wr(18'h2AA, 8'h55, 1'b0);
            else if (i == 2) wr(18'h555, 8'hA0, 1'b0);
            else             wr(18'h00100 + 18'(k), 8'hC3, 1'b0);
         end
         exp_req(1, 18'h00100 + 18'(k), 8'hC3, "R8 program survives busy");
      end
      // R8 busy F0 does not exit id mode
      key_pair(18'h0);
      wr(18'h555, 8'h90, 1'b0);
      wr(18'h0, 8'hF0, 1'b1);
      exp_req(0, 0, 0, "R8 busy exit ignored");
      chk(id_mode == 1'b1, "R8 id_mode kept", int'(id_mode), 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule